// File: doc/BRIEF.md
# Extended-precision rounding unit with precision control

This block takes an unbounded intermediate value and turns it into a finished 80-bit extended-precision result. The value is a sign, a 32-bit signed exponent and a 128-bit significand. The significand comes as two 64-bit words: the high word carries the explicit integer bit at bit 63, and the low word holds the bits below it. A precision selector narrows the kept significand to 24, 53 or 64 bits. The result stays in the 80-bit layout in every case: bit 79 is the sign, bits 78:64 are the biased exponent and bits 63:0 are the significand.

The unit rounds in the requested direction. It replaces an overflowing value with infinity or with the largest finite number, and it denormalizes values that are too small for the normal range. Alongside the result it reports four flags: overflow, underflow, inexact and rounded-up. An underflow or overflow can be unmasked. In that case the unit shifts the exponent by a fixed bias (0x6000 by default) and rounds the value a second time through the same datapath. That second pass costs one extra cycle.

A caller pulses `start_i` with the operand and waits for the one-cycle `done_o` strobe. The result and flags stay on the outputs until the next operation finishes.

Top module: `xr_round_unit`

## Requirements
- R1: `prec_i` sets how many significand bits are kept: 00 keeps 24 bits and clears result bits 39:0; 10 keeps 53 bits and clears result bits 10:0; 11 keeps all 64 bits, and so does 01. In the 24-bit and 53-bit settings, a nonzero low word acts as a sticky 1 in bit 0 of the high word.
- R2: With `rmode_i` = 00 (nearest, ties to even), a discarded part above half an LSB rounds up, one below half truncates, and an exact half rounds to the even neighbour. `rup_o` is set exactly when the rounded significand is larger than the exact one; `inx_o` is set whenever any discarded bit is nonzero.
- R3: With `rmode_i` = 01 the unit rounds toward minus infinity, with 10 toward plus infinity, and with 11 toward zero. A directed mode adds a full LSB minus one only when its direction points away from zero for the operand's sign.
- R4: When rounding carries out of significand bit 63, the exponent goes up by one and the significand becomes 0x8000000000000000.
- R5: Overflow occurs when the exponent is above 0x7FFE, or equals 0x7FFE and rounding carries out of the significand. It raises `ovf_o`, and when overflow is masked it also raises `inx_o`.
- R6: A masked overflow returns the largest finite value in three cases: toward-zero mode, a negative operand with toward-plus rounding, and a positive operand with toward-minus rounding. That value has exponent 0x7FFE and all kept significand bits set to one. Every other masked overflow returns infinity (exponent 0x7FFF, significand 0x8000000000000000) and sets `rup_o`.
- R7: An exponent of 0 or below shifts the significand right by one minus the exponent. Shifted-out bits are kept as a sticky bit, and the exponent field becomes 0. If rounding then sets bit 63, the field becomes 1. A zero exponent field never comes with significand bit 63 set.
- R8: `unf_o` is raised for a tiny value when bits are discarded by denormalization, or when the denormalized significand is nonzero and `unf_mask_i` is 0. Tininess is judged before the denormalizing shift.
- R9: An underflow with `unf_mask_i` = 0 re-rounds the value with its exponent increased by 0x6000. The reported flags are underflow together with the flags of the second pass only.
- R10: An overflow with `ovf_mask_i` = 0 (and no unmasked underflow) re-rounds the value with its exponent decreased by 0x6000. The reported flags are overflow together with the flags of the second pass only.
- R11: A `start_i` sampled while idle produces a one-cycle `done_o` two clock edges later, or three when a second pass is taken. A `start_i` sampled while an operation is in flight is ignored.
- R12: During and after reset, `done_o`, `result_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with the operand on the inputs |
| sign_i | input | 1 | Operand sign |
| exp_i | input | EXP_W (32) | Operand exponent, two's complement, biased |
| sig_hi_i | input | 64 | Upper significand word, integer bit at bit 63 |
| sig_lo_i | input | 64 | Lower significand word |
| prec_i | input | 2 | Precision selection (R1) |
| rmode_i | input | 2 | Rounding direction (R2, R3) |
| ovf_mask_i | input | 1 | 1 masks overflow, 0 requests the rebiased second pass |
| unf_mask_i | input | 1 | 1 masks underflow, 0 requests the rebiased second pass |
| done_o | output | 1 | One-cycle strobe: result and flags are valid |
| result_o | output | 80 | Sign, 15-bit exponent, 64-bit significand |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |
| rup_o | output | 1 | Rounded-up flag: result magnitude exceeds the exact value |

## Verification
The bench targets exact halfway ties in all three precisions, because a design that skips the even-clearing step returns a significand one LSB too large. It also targets carries out of bit 63 at both reduced and full precision, where a missing renormalization leaves a zero significand. At the exponent edge 0x7FFE it checks that overflow is detected only when rounding actually carries. For each direction and sign it checks the choice between infinity and largest-finite, since mixing those up flips both the result and the rounded-up flag. In the subnormal range it drives cases that round back into the normal range and that lose bits into the sticky position; there a wrong tininess test shows up as a spurious or missing underflow. Both rebiased second passes are checked for their extra cycle and for flags that keep only the first pass's exception, and a start arriving mid-operation must leave the in-flight result untouched.

// File: rtl/xr_pkg.sv
package xr_pkg;

   localparam int SIG_W = 64;

   typedef enum logic [1:0] {
      PC_24  = 2'b00,
      PC_RSV = 2'b01,
      PC_53  = 2'b10,
      PC_64  = 2'b11
   } xr_prec_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } xr_rmode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_PASS1 = 2'b01,
      ST_PASS2 = 2'b10
   } xr_state_e;

   // Right shift of {a0,a1} by n with jamming: returns {upper word, lower word};
   // bits falling off the lower word, and all of a1, collapse into bit 0.
   function automatic logic [127:0] xr_shift_jam(input logic [63:0] a0,
                                                 input logic [63:0] a1,
                                                 input logic [7:0]  n);
      logic [191:0] big;
      logic [127:0] r;
      if (n >= 8'd128) begin
         r = {64'd0, 63'd0, |{a0, a1}};
      end else begin
         big = {a0, 128'd0} >> n;
         r   = {big[191:128], big[127:65], big[64] | (|big[63:0]) | (|a1)};
      end
      return r;
   endfunction

endpackage

// File: rtl/xr_prec_decode.sv
module xr_prec_decode
   import xr_pkg::*;
#(
   parameter int W      = SIG_W,
   parameter int NARROW = 24,
   parameter int MEDIUM = 53
) (
   input  xr_prec_e       prec_i,
   output logic           full_o,
   output logic [W-1:0]   mask_o,
   output logic [W-1:0]   half_o
);

   localparam logic [W-1:0] MASK_N = {{NARROW{1'b0}}, {(W-NARROW){1'b1}}};
   localparam logic [W-1:0] HALF_N = {{NARROW{1'b0}}, 1'b1, {(W-NARROW-1){1'b0}}};
   localparam logic [W-1:0] MASK_M = {{MEDIUM{1'b0}}, {(W-MEDIUM){1'b1}}};
   localparam logic [W-1:0] HALF_M = {{MEDIUM{1'b0}}, 1'b1, {(W-MEDIUM-1){1'b0}}};

   if (NARROW < 2 || NARROW >= MEDIUM || MEDIUM >= W) begin : g_bad_prec
      $error("xr_prec_decode: need 2 <= NARROW < MEDIUM < W");
   end

   always_comb begin
      full_o = 1'b0;
      mask_o = '0;
      half_o = '0;
      unique case (prec_i)
         PC_24: begin mask_o = MASK_N; half_o = HALF_N; end
         PC_53: begin mask_o = MASK_M; half_o = HALF_M; end
         default: full_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/xr_round_core.sv
module xr_round_core
   import xr_pkg::*;
#(
   parameter int EXP_W = 32
) (
   input  logic                    sign_i,
   input  logic signed [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0]        hi_i,
   input  logic [SIG_W-1:0]        lo_i,
   input  xr_prec_e                prec_i,
   input  xr_rmode_e               rmode_i,
   input  logic                    unf_mask_i,
   output logic [79:0]             res_o,
   output logic                    ovf_o,
   output logic                    unf_o,
   output logic                    inx_o,
   output logic                    rup_o
);

   localparam int EMAX = 32'h7FFE;
   localparam logic [SIG_W-1:0] TOP = {1'b1, {(SIG_W-1){1'b0}}};
   localparam logic [SIG_W-1:0] ONES = '1;

   logic             full;
   logic [SIG_W-1:0] mask, half;

   xr_prec_decode u_dec (
      .prec_i (prec_i),
      .full_o (full),
      .mask_o (mask),
      .half_o (half)
   );

   logic                    near, away, keep_max, tiny, incb;
   logic signed [EXP_W-1:0] e;
   logic [EXP_W:0]          n_w;
   logic [7:0]              n;
   logic [SIG_W-1:0]        s, exact, rbits, inc, clr, z1;
   logic [SIG_W:0]          sum;
   logic [127:0]            sh;
   logic                    ovf_hit;

   always_comb begin
      near     = (rmode_i == RM_NEAR);
      away     = (rmode_i == RM_UP && !sign_i) || (rmode_i == RM_DOWN && sign_i);
      keep_max = !near && !away;
      n_w      = (EXP_W+1)'(1) - {exp_i[EXP_W-1], exp_i};
      n        = (n_w >= (EXP_W+1)'(128)) ? 8'd128 : n_w[7:0];
      e        = exp_i;
      s        = '0;
      exact    = '0;
      rbits    = '0;
      inc      = '0;
      clr      = '0;
      z1       = '0;
      sum      = '0;
      sh       = '0;
      tiny     = 1'b0;
      incb     = 1'b0;
      ovf_hit  = 1'b0;
      ovf_o    = 1'b0;
      unf_o    = 1'b0;
      inx_o    = 1'b0;
      rup_o    = 1'b0;
      res_o    = '0;
      if (!full) begin
         s     = hi_i | {{(SIG_W-1){1'b0}}, |lo_i};
         inc   = near ? half : (away ? mask : '0);
         rbits = s & mask;
         sum   = {1'b0, s} + {1'b0, inc};
         if (exp_i > EMAX || (exp_i == EMAX && sum[SIG_W])) begin
            ovf_hit = 1'b1;
         end else if (exp_i <= 0) begin
            tiny  = (exp_i < 0) || !sum[SIG_W];
            sh    = xr_shift_jam(s, '0, n);
            s     = sh[127:64] | {{(SIG_W-1){1'b0}}, |sh[63:0]};
            exact = s;
            rbits = s & mask;
            unf_o = tiny && (rbits != '0 || (s != '0 && !unf_mask_i));
            inx_o = rbits != '0;
            sum   = {1'b0, s} + {1'b0, inc};
            clr   = mask | ((near && rbits == half) ? (mask + 1'b1) : '0);
            s     = sum[SIG_W-1:0] & ~clr;
            e     = s[SIG_W-1] ? EXP_W'(1) : '0;
            rup_o = s > exact;
            res_o = {sign_i, e[14:0], s};
         end else begin
            inx_o = rbits != '0;
            exact = s;
            if (sum[SIG_W]) begin
               e     = exp_i + 1'b1;
               s     = TOP;
               exact = exact >> 1;
            end else begin
               s = sum[SIG_W-1:0];
            end
            clr   = mask | ((near && rbits == half) ? (mask + 1'b1) : '0);
            s     = s & ~clr;
            rup_o = s > exact;
            if (s == '0) e = '0;
            res_o = {sign_i, e[14:0], s};
         end
      end else begin
         incb = near ? lo_i[SIG_W-1] : (away && lo_i != '0);
         if (exp_i > EMAX || (exp_i == EMAX && hi_i == ONES && incb)) begin
            ovf_hit = 1'b1;
         end else if (exp_i <= 0) begin
            tiny  = (exp_i < 0) || !incb || (hi_i != ONES);
            sh    = xr_shift_jam(hi_i, lo_i, n);
            exact = sh[127:64];
            z1    = sh[63:0];
            unf_o = tiny && (z1 != '0 || (exact != '0 && !unf_mask_i));
            inx_o = z1 != '0;
            incb  = near ? z1[SIG_W-1] : (away && z1 != '0);
            s     = exact;
            if (incb) begin
               s = exact + 1'b1;
               if (near && z1[SIG_W-2:0] == '0) s[0] = 1'b0;
            end
            rup_o = s > exact;
            e     = s[SIG_W-1] ? EXP_W'(1) : '0;
            res_o = {sign_i, e[14:0], s};
         end else begin
            inx_o = lo_i != '0;
            s     = hi_i;
            if (incb) begin
               if (hi_i == ONES) begin
                  e = exp_i + 1'b1;
                  s = TOP;
               end else begin
                  s = hi_i + 1'b1;
                  if (near && lo_i[SIG_W-2:0] == '0) s[0] = 1'b0;
               end
               rup_o = (hi_i == ONES) || (s > hi_i);
            end else if (hi_i == '0) begin
               e = '0;
            end
            res_o = {sign_i, e[14:0], s};
         end
      end
      if (ovf_hit) begin
         ovf_o = 1'b1;
         inx_o = 1'b1;
         unf_o = 1'b0;
         if (keep_max) begin
            res_o = {sign_i, 15'h7FFE, ~mask};
         end else begin
            res_o = {sign_i, 15'h7FFF, TOP};
            rup_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/xr_round_unit.sv
module xr_round_unit
   import xr_pkg::*;
#(
   parameter int EXP_W  = 32,
   parameter int REBIAS = 32'h6000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             sign_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic [63:0]      sig_hi_i,
   input  logic [63:0]      sig_lo_i,
   input  logic [1:0]       prec_i,
   input  logic [1:0]       rmode_i,
   input  logic             ovf_mask_i,
   input  logic             unf_mask_i,
   output logic             done_o,
   output logic [79:0]      result_o,
   output logic             ovf_o,
   output logic             unf_o,
   output logic             inx_o,
   output logic             rup_o
);

   localparam logic signed [EXP_W-1:0] REBIAS_E = EXP_W'(REBIAS);

   if (EXP_W < 17 || EXP_W > 32) begin : g_bad_exp
      $error("xr_round_unit: EXP_W must lie in 17..32");
   end
   if (REBIAS <= 0 || REBIAS >= 32'h8000) begin : g_bad_bias
      $error("xr_round_unit: REBIAS must lie inside the 15-bit exponent range");
   end

   xr_state_e               state_q;
   logic                    sign_q, omask_q, umask_q, keep_ovf_q, keep_unf_q;
   logic signed [EXP_W-1:0] exp_q;
   logic [SIG_W-1:0]        hi_q, lo_q;
   xr_prec_e                prec_q;
   xr_rmode_e               rmode_q;

   logic [79:0] c_res;
   logic        c_ovf, c_unf, c_inx, c_rup;
   logic        redo_unf, redo_ovf, finish;

   xr_round_core #(.EXP_W(EXP_W)) u_core (
      .sign_i     (sign_q),
      .exp_i      (exp_q),
      .hi_i       (hi_q),
      .lo_i       (lo_q),
      .prec_i     (prec_q),
      .rmode_i    (rmode_q),
      .unf_mask_i (umask_q),
      .res_o      (c_res),
      .ovf_o      (c_ovf),
      .unf_o      (c_unf),
      .inx_o      (c_inx),
      .rup_o      (c_rup)
   );

   always_comb begin
      redo_unf = (state_q == ST_PASS1) && c_unf && !umask_q;
      redo_ovf = (state_q == ST_PASS1) && !redo_unf && c_ovf && !omask_q;
      finish   = ((state_q == ST_PASS1) && !redo_unf && !redo_ovf) || (state_q == ST_PASS2);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         sign_q     <= 1'b0;
         exp_q      <= '0;
         hi_q       <= '0;
         lo_q       <= '0;
         prec_q     <= PC_64;
         rmode_q    <= RM_NEAR;
         omask_q    <= 1'b1;
         umask_q    <= 1'b1;
         keep_ovf_q <= 1'b0;
         keep_unf_q <= 1'b0;
         done_o     <= 1'b0;
         result_o   <= '0;
         ovf_o      <= 1'b0;
         unf_o      <= 1'b0;
         inx_o      <= 1'b0;
         rup_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (state_q == ST_IDLE && start_i) begin
            sign_q     <= sign_i;
            exp_q      <= exp_i;
            hi_q       <= sig_hi_i;
            lo_q       <= sig_lo_i;
            prec_q     <= xr_prec_e'(prec_i);
            rmode_q    <= xr_rmode_e'(rmode_i);
            omask_q    <= ovf_mask_i;
            umask_q    <= unf_mask_i;
            keep_ovf_q <= 1'b0;
            keep_unf_q <= 1'b0;
            state_q    <= ST_PASS1;
         end
         if (redo_unf) begin
            exp_q      <= exp_q + REBIAS_E;
            keep_unf_q <= 1'b1;
            state_q    <= ST_PASS2;
         end
         if (redo_ovf) begin
            exp_q      <= exp_q - REBIAS_E;
            keep_ovf_q <= 1'b1;
            state_q    <= ST_PASS2;
         end
         if (finish) begin
            result_o <= c_res;
            ovf_o    <= c_ovf | keep_ovf_q;
            unf_o    <= c_unf | keep_unf_q;
            inx_o    <= c_inx;
            rup_o    <= c_rup;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
         end
      end
   end

   // R1
   narrow_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && prec_q == PC_24) |-> (result_o[39:0] == '0));

   // R1
   medium_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && prec_q == PC_53) |-> (result_o[10:0] == '0));

   // R5
   ovf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && ovf_o && omask_q) |-> inx_o);

   // R6
   inf_rup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && result_o[78:0] == {15'h7FFF, 1'b1, 63'd0}) |-> rup_o);

   // R7
   subnorm_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && result_o[78:64] == '0) |-> !result_o[63]);

   // R11
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11
   start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> $stable(hi_q) && $stable(lo_q));

endmodule

// File: tb/xr_round_unit_bench.sv
`timescale 1ns/1ps
module xr_round_unit_bench;

   localparam logic [63:0] TOP  = 64'h8000000000000000;
   localparam logic [63:0] ONES = 64'hFFFFFFFFFFFFFFFF;

   typedef struct packed {
      logic [23:0] tag;
      logic        sgn;
      logic [31:0] e;
      logic [63:0] hi;
      logic [63:0] lo;
      logic [1:0]  pc;
      logic [1:0]  rm;
      logic        om;
      logic        um;
      logic [79:0] res;
      logic [3:0]  fl;   // {ovf, unf, inx, rup}
      logic        two;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{"R2",  1'b0, 32'h3FFF, TOP, 64'h0, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0000, 1'b0},
      '{"R2",  1'b0, 32'h3FFF, 64'h8000000000000001, TOP, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000000002}, 4'b0011, 1'b0},
      '{"R2",  1'b0, 32'h3FFF, TOP, TOP, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R2",  1'b0, 32'h3FFF, TOP, 64'h8000000000000001, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000000001}, 4'b0011, 1'b0},
      '{"R3",  1'b0, 32'h3FFF, TOP, 64'h1, 2'b11, 2'b10, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000000001}, 4'b0011, 1'b0},
      '{"R3",  1'b1, 32'h3FFF, TOP, 64'h1, 2'b11, 2'b10, 1'b1, 1'b1, {1'b1, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R3",  1'b1, 32'h3FFF, TOP, 64'h1, 2'b11, 2'b01, 1'b1, 1'b1, {1'b1, 15'h3FFF, 64'h8000000000000001}, 4'b0011, 1'b0},
      '{"R3",  1'b0, 32'h3FFF, TOP, ONES, 2'b11, 2'b11, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R4",  1'b0, 32'h3FFF, ONES, TOP, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h4000, TOP}, 4'b0011, 1'b0},
      '{"R1",  1'b0, 32'h3FFF, 64'h8000000000000400, 64'h0, 2'b10, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R1",  1'b0, 32'h3FFF, 64'h8000000000000C00, 64'h0, 2'b10, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000001000}, 4'b0011, 1'b0},
      '{"R1",  1'b0, 32'h3FFF, 64'h8000000000000400, 64'h1, 2'b10, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000000800}, 4'b0011, 1'b0},
      '{"R1",  1'b0, 32'h3FFF, 64'h8000008000000000, 64'h0, 2'b00, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R3",  1'b0, 32'h3FFF, 64'h8000000000000001, 64'h0, 2'b00, 2'b10, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000010000000000}, 4'b0011, 1'b0},
      '{"R4",  1'b0, 32'h3FFF, 64'hFFFFFF8000000000, 64'h0, 2'b00, 2'b00, 1'b1, 1'b1, {1'b0, 15'h4000, TOP}, 4'b0011, 1'b0},
      '{"R5",  1'b0, 32'h7FFF, TOP, 64'h0, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h7FFF, TOP}, 4'b1011, 1'b0},
      '{"R6",  1'b1, 32'h8000, TOP, 64'h0, 2'b11, 2'b11, 1'b1, 1'b1, {1'b1, 15'h7FFE, ONES}, 4'b1010, 1'b0},
      '{"R6",  1'b1, 32'h7FFF, TOP, 64'h0, 2'b10, 2'b10, 1'b1, 1'b1, {1'b1, 15'h7FFE, 64'hFFFFFFFFFFFFF800}, 4'b1010, 1'b0},
      '{"R5",  1'b0, 32'h7FFE, 64'hFFFFFF8000000000, 64'h0, 2'b00, 2'b00, 1'b1, 1'b1, {1'b0, 15'h7FFF, TOP}, 4'b1011, 1'b0},
      '{"R5",  1'b0, 32'h7FFE, ONES, 64'h0, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h7FFE, ONES}, 4'b0000, 1'b0},
      '{"R7",  1'b0, 32'h0, TOP, 64'h0, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h0000, 64'h4000000000000000}, 4'b0000, 1'b0},
      '{"R9",  1'b0, 32'h0, TOP, 64'h0, 2'b11, 2'b00, 1'b1, 1'b0, {1'b0, 15'h6000, TOP}, 4'b0100, 1'b1},
      '{"R8",  1'b0, 32'hFFFFFFFF, 64'h8000000000000001, 64'h0, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h0000, 64'h2000000000000000}, 4'b0110, 1'b0},
      '{"R7",  1'b0, 32'h0, ONES, TOP, 2'b11, 2'b00, 1'b1, 1'b1, {1'b0, 15'h0001, TOP}, 4'b0011, 1'b0},
      '{"R8",  1'b0, 32'h0, 64'h8000000000000C00, 64'h0, 2'b10, 2'b00, 1'b1, 1'b1, {1'b0, 15'h0000, 64'h4000000000000800}, 4'b0111, 1'b0},
      '{"R10", 1'b0, 32'h8000, TOP, 64'h0, 2'b11, 2'b00, 1'b0, 1'b1, {1'b0, 15'h2000, TOP}, 4'b1000, 1'b1},
      '{"R3",  1'b0, 32'h3FFF, 64'h80000000000007FF, 64'h0, 2'b10, 2'b01, 1'b1, 1'b1, {1'b0, 15'h3FFF, TOP}, 4'b0010, 1'b0},
      '{"R1",  1'b0, 32'h3FFF, 64'h8000000000000400, 64'h0, 2'b01, 2'b00, 1'b1, 1'b1, {1'b0, 15'h3FFF, 64'h8000000000000400}, 4'b0000, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sgn = 1'b0;
   logic [31:0] e_in = '0;
   logic [63:0] hi = '0, lo = '0;
   logic [1:0]  pc = '0, rm = '0;
   logic        om = 1'b1, um = 1'b1;
   logic        done, ovf, unf, inx, rup;
   logic [79:0] result;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   xr_round_unit u_xr_round_unit (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .sign_i     (sgn),
      .exp_i      (e_in),
      .sig_hi_i   (hi),
      .sig_lo_i   (lo),
      .prec_i     (pc),
      .rmode_i    (rm),
      .ovf_mask_i (om),
      .unf_mask_i (um),
      .done_o     (done),
      .result_o   (result),
      .ovf_o      (ovf),
      .unf_o      (unf),
      .inx_o      (inx),
      .rup_o      (rup)
   );

   task automatic chk(input bit ok, input string what, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      sgn = v.sgn; e_in = v.e; hi = v.hi; lo = v.lo;
      pc = v.pc; rm = v.rm; om = v.om; um = v.um;
   endtask

   task automatic run_vec(input int idx, input vec_t v);
      int lat;
      @(negedge clk);
      drive(v);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      for (int k = 0; k < 5; k++) begin
         if (done) break;
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      // R11: latency one edge after capture, two with a second pass
      chk(lat == (v.two ? 2 : 1), $sformatf("R11 vec %0d (%s) latency", idx, v.tag),
          80'(lat), 80'(v.two ? 2 : 1));
      chk(result == v.res, $sformatf("%s vec %0d result", v.tag, idx), result, v.res);
      chk({ovf, unf, inx, rup} == v.fl, $sformatf("%s vec %0d flags", v.tag, idx),
          80'({ovf, unf, inx, rup}), 80'(v.fl));
      @(negedge clk);
      chk(!done, $sformatf("R11 vec %0d done pulse width", idx), 80'(done), 80'(0));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL R11 watchdog: actual %0d cycles expected under 20000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk({done, ovf, unf, inx, rup} == 5'b0 && result == '0, "R12 outputs in reset",
          {result[74:0], done, ovf, unf, inx, rup}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk({done, ovf, unf, inx, rup} == 5'b0 && result == '0, "R12 outputs after reset",
          {result[74:0], done, ovf, unf, inx, rup}, '0);

      for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

      // R11: start while an operation (with a second pass) is in flight is ignored
      @(negedge clk);
      drive(VEC[21]);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      drive(VEC[8]);
      @(posedge clk);
      @(negedge clk);
      chk(!done, "R11 busy no early done", 80'(done), 80'(0));
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R11 busy done on third edge", 80'(done), 80'(1));
      chk(result == VEC[21].res, "R11 busy result from first operand (R9)", result, VEC[21].res);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!done, "R11 ignored start gives no done", 80'(done), 80'(0));
      end
      chk(result == VEC[21].res, "R11 result held after ignored start", result, VEC[21].res);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule